// File: doc/BRIEF.md
# UDP Datagram Detector and Marker

This block sits behind the IP header stage of a receive path. It watches a framed 32-bit word stream in which every IP packet is delimited by start-of-frame and end-of-frame markers, and in which a start-of-payload marker flags the first word after the IP header. It reads the protocol byte of the IP header. When that byte says UDP, the block raises a one-cycle start-of-datagram strobe on the first UDP header word. It also verifies the UDP checksum and flags a mismatch together with end-of-frame.

Data, data enable and all markers are forwarded to the application side through a single register stage. Only words with data enable high count as stream words. The application's ready signal is passed straight back to the upstream stage. Words already inside the block are still delivered after ready drops.

Top module: `udp_marker`

## Requirements
- R1: Every input (data, enable, start-of-frame, start-of-payload, end-of-frame) appears on the matching output exactly one clock later, unchanged.
- R2: A packet is UDP only when bits 23:16 of its third enabled word (the start-of-frame word counts as the first) equal 17.
- R3: For a UDP packet, `out_sod` is high for one clock, in the same cycle that `out_sop` presents the first UDP header word.
- R4: `out_sod` stays low for every packet whose protocol byte is not 17.
- R5: Cycles with `in_en` low are ignored by the word counting, the header capture and the checksum, whatever data or markers they carry.
- R6: A UDP packet whose received checksum (bits 15:0 of the second UDP header word) is zero never raises `out_ck_bad`.
- R7: For a UDP packet with a nonzero checksum, `out_ck_bad` is high with `out_eof` exactly when the ones'-complement sum fails to fold to 0xFFFF. The sum covers the source and destination addresses (fourth and fifth header words), the protocol value 17, the UDP length (bits 31:16 of the second UDP word), and the UDP header plus payload. At every other time `out_ck_bad` is low.
- R8: Bytes of the last word that lie past the UDP length are treated as zero, so an odd final byte is padded with zero and any trailing garbage is ignored.
- R9: `up_ready` equals `app_ready` in the same cycle, and words already accepted are still delivered after `app_ready` falls.
- R10: Reset is synchronous and active low; the clock after reset is sampled low, all outputs except `up_ready` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 32 | Stream word from the IP stage |
| in_en | input | 1 | Word valid |
| in_sof | input | 1 | First IP header word |
| in_sop | input | 1 | First word after the IP header |
| in_eof | input | 1 | Last word of the packet |
| up_ready | output | 1 | Backpressure toward the IP stage, high means send |
| out_data | output | 32 | Stream word to the application |
| out_en | output | 1 | Word valid |
| out_sof | output | 1 | Start of frame |
| out_sop | output | 1 | Start of IP payload |
| out_eof | output | 1 | End of frame |
| out_sod | output | 1 | Start of UDP datagram |
| out_ck_bad | output | 1 | UDP checksum mismatch, valid with out_eof |
| app_ready | input | 1 | Backpressure from the application |

## Verification
The bench goes after header-only datagrams, where the checksum word is also the last word; a design that read the checksum from a stale register would misjudge them. It sends odd payload lengths with garbage in the unused trailing bytes, which catches a design that sums whole words past the length. Idle cycles carrying marker-like data are scattered through the header, so a counter that advances without data enable would take the protocol from the wrong word and place the datagram strobe wrongly. Zero checksums, non-UDP protocols carrying corrupt fields, and IP options that move the UDP header check that the strobe and the error flag follow only the protocol byte.

// File: rtl/udp_marker.sv
module udp_marker #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] in_data,
  input  logic        in_en,
  input  logic        in_sof,
  input  logic        in_sop,
  input  logic        in_eof,
  output logic        up_ready,
  output logic [31:0] out_data,
  output logic        out_en,
  output logic        out_sof,
  output logic        out_sop,
  output logic        out_eof,
  output logic        out_sod,
  output logic        out_ck_bad,
  input  logic        app_ready
);
  localparam int BW = CNT_W + 2;

  logic [2:0]       wcnt_q;
  logic [CNT_W-1:0] u_q;
  logic             act_q, is_udp_q;
  logic [15:0]      len_q, ck_q;
  logic [31:0]      acc_q;

  logic [2:0]       idx;
  logic [CNT_W-1:0] u_now;
  logic             region, hdr_w1;
  logic [15:0]      len_now, ck_now;
  logic [BW-1:0]    boff;
  logic [3:0]       keep;
  logic [31:0]      mdata;
  logic [31:0]      add, acc_next;
  logic [16:0]      s1, s2;
  logic             bad_now, sod_now;

  assign up_ready = app_ready;

  assign idx     = in_sof ? 3'd0 : wcnt_q;
  assign region  = in_sop | act_q;
  assign u_now   = in_sop ? '0 : u_q;
  assign hdr_w1  = (u_now == CNT_W'(1));
  assign len_now = hdr_w1 ? in_data[31:16] : len_q;
  assign ck_now  = hdr_w1 ? in_data[15:0]  : ck_q;
  assign boff    = {u_now, 2'b00};

  for (genvar j = 0; j < 4; j++) begin : g_keep
    assign keep[j] = (u_now == '0) || ((boff + BW'(j)) < BW'(len_now));
    assign mdata[31-8*j -: 8] = keep[j] ? in_data[31-8*j -: 8] : 8'h00;
  end

  always_comb begin
    add = 32'd0;
    if (region) begin
      add = 32'(mdata[31:16]) + 32'(mdata[15:0]);
      if (hdr_w1) add = add + 32'(in_data[31:16]) + 32'd17;
    end else if (idx == 3'd3 || idx == 3'd4) begin
      add = 32'(in_data[31:16]) + 32'(in_data[15:0]);
    end
  end

  assign acc_next = (in_sof ? 32'd0 : acc_q) + add;
  assign s1 = 17'(acc_next[15:0]) + 17'(acc_next[31:16]);
  assign s2 = 17'(s1[15:0]) + 17'(s1[16]);

  assign bad_now = in_en & in_eof & region & is_udp_q &
                   (ck_now != 16'h0000) & (s2[15:0] != 16'hFFFF);
  assign sod_now = in_en & in_sop & is_udp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q   <= 3'd0;
      u_q      <= '0;
      act_q    <= 1'b0;
      is_udp_q <= 1'b0;
      len_q    <= 16'd0;
      ck_q     <= 16'd0;
      acc_q    <= 32'd0;
    end else if (in_en) begin
      wcnt_q <= (idx == 3'd7) ? 3'd7 : idx + 3'd1;
      acc_q  <= acc_next;
      if (in_sof)             is_udp_q <= 1'b0;
      else if (idx == 3'd2)   is_udp_q <= (in_data[23:16] == 8'd17);
      act_q <= region & ~in_eof;
      if (region) begin
        u_q <= u_now + CNT_W'(1);
        if (hdr_w1) begin
          len_q <= in_data[31:16];
          ck_q  <= in_data[15:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data   <= 32'd0;
      out_en     <= 1'b0;
      out_sof    <= 1'b0;
      out_sop    <= 1'b0;
      out_eof    <= 1'b0;
      out_sod    <= 1'b0;
      out_ck_bad <= 1'b0;
    end else begin
      out_data   <= in_data;
      out_en     <= in_en;
      out_sof    <= in_sof;
      out_sop    <= in_sop;
      out_eof    <= in_eof;
      out_sod    <= sod_now;
      out_ck_bad <= bad_now;
    end
  end
endmodule

module udp_marker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] in_data,
  input logic        in_en,
  input logic [31:0] out_data,
  input logic        out_en,
  input logic        out_sop,
  input logic        out_eof,
  input logic        out_sod,
  input logic        out_ck_bad,
  input logic        up_ready,
  input logic        app_ready
);
  p_data_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_data == $past(in_data) && out_en == $past(in_en)));
  p_sod_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_sod |=> !out_sod);
  p_sod_on_sop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_sod |-> (out_sop && out_en));
  p_bad_with_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_ck_bad |-> (out_eof && out_en));
  p_ready_follow_r9: assert property (@(posedge clk)
    up_ready == app_ready);
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> (!out_en && !out_sod && !out_ck_bad));
endmodule

bind udp_marker udp_marker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_en(in_en),
  .out_data(out_data), .out_en(out_en), .out_sop(out_sop), .out_eof(out_eof),
  .out_sod(out_sod), .out_ck_bad(out_ck_bad), .up_ready(up_ready),
  .app_ready(app_ready)
);

// File: tb/tb_udp_marker.sv
`timescale 1ns/1ps
module tb_udp_marker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [31:0] in_data;
  logic        in_en, in_sof, in_sop, in_eof;
  logic        up_ready;
  logic [31:0] out_data;
  logic        out_en, out_sof, out_sop, out_eof, out_sod, out_ck_bad;
  logic        app_ready;

  udp_marker dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_en(in_en),
    .in_sof(in_sof), .in_sop(in_sop), .in_eof(in_eof), .up_ready(up_ready),
    .out_data(out_data), .out_en(out_en), .out_sof(out_sof), .out_sop(out_sop),
    .out_eof(out_eof), .out_sod(out_sod), .out_ck_bad(out_ck_bad),
    .app_ready(app_ready)
  );

  int checks = 0, errors = 0;
  bit armed = 0;
  logic [31:0] p_d;
  logic p_en, p_sof, p_sop, p_eof, p_sod, p_bad;
  string bad_req = "R7";

  task automatic fail(input string req, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic compare();
    checks++;
    if ({out_en, out_sof, out_sop, out_eof} != {p_en, p_sof, p_sop, p_eof} ||
        (p_en && out_data != p_d))
      fail("R1", {out_data, 28'd0, out_en, out_sof, out_sop, out_eof},
                 {p_d, 28'd0, p_en, p_sof, p_sop, p_eof});
    checks++;
    if (out_sod != p_sod) fail(p_sod ? "R2/R3" : "R4", 64'(out_sod), 64'(p_sod));
    checks++;
    if (out_ck_bad != p_bad) fail(bad_req, 64'(out_ck_bad), 64'(p_bad));
  endtask

  task automatic step(input logic [31:0] d, input logic en, sof, sop, eof, xsod, xbad);
    @(negedge clk);
    if (armed) compare();
    in_data = d; in_en = en; in_sof = sof; in_sop = sop; in_eof = eof;
    app_ready = 1'($urandom_range(0, 1));
    #1;
    checks++;
    if (up_ready != app_ready) fail("R9", 64'(up_ready), 64'(app_ready));
    p_d = d; p_en = en; p_sof = sof; p_sop = sop; p_eof = eof;
    p_sod = xsod; p_bad = xbad; armed = 1;
  endtask

  function automatic logic [15:0] fold(input logic [31:0] s);
    logic [31:0] t = s;
    while (t[31:16] != 16'd0) t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
    return t[15:0];
  endfunction

  // mode 0: correct checksum, 1: zero checksum (R6), 2: corrupted (R7)
  task automatic send_pkt(input logic [7:0] proto, input int ihl, input int plen,
                          input int mode, input int gap_pct);
    logic [31:0] w [0:39];
    int ulen, n;
    logic [31:0] s;
    logic [15:0] ck;
    logic [7:0] b;
    bit xbad;
    ulen = 8 + plen;
    n = ihl + (ulen + 3) / 4;
    for (int k = 0; k < 40; k++) w[k] = $urandom;
    w[0] = {4'h4, 4'(ihl), 8'h00, 16'(ihl * 4 + ulen)};
    w[2][23:16] = proto;
    w[ihl + 1] = {16'(ulen), 16'h0000};
    s = 32'(w[3][31:16]) + 32'(w[3][15:0]) + 32'(w[4][31:16]) + 32'(w[4][15:0])
      + 32'd17 + 32'(ulen);
    for (int i = 0; i < ulen; i++) begin
      b = w[ihl + i / 4][31 - 8 * (i % 4) -: 8];
      s = s + ((i % 2 == 0) ? {16'd0, b, 8'd0} : {24'd0, b});
    end
    ck = ~fold(s);
    if (ck == 16'h0000) ck = 16'hFFFF;
    if (mode == 1) ck = 16'h0000;
    if (mode == 2) ck = (ck == 16'hFFFF) ? 16'h0001 : ck + 16'd1;
    w[ihl + 1][15:0] = ck;
    xbad = (proto == 8'd17) && (mode == 2);
    bad_req = (mode == 1) ? "R6" : ((plen % 4 != 0) ? "R7/R8" : "R7");
    for (int k = 0; k < n; k++) begin
      while ($urandom_range(0, 99) < gap_pct)            // R5 idle cycles
        step($urandom, 1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'b0, 1'b0, 1'b0);
      step(w[k], 1'b1, k == 0, k == ihl, k == n - 1,
           (proto == 8'd17) && (k == ihl), xbad && (k == n - 1));
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_data = 32'hFFFF_FFFF; in_en = 1'b1; in_sof = 1'b1;
    in_sop = 1'b1; in_eof = 1'b1; app_ready = 1'b1;
    repeat (3) @(negedge clk);
    checks++;                                            // R10
    if ({out_en, out_sof, out_sop, out_eof, out_sod, out_ck_bad} != 6'd0 || out_data != 0)
      fail("R10", {out_data, 26'd0, out_en, out_sof, out_sop, out_eof, out_sod, out_ck_bad}, 64'd0);
    in_en = 1'b0; in_sof = 1'b0; in_sop = 1'b0; in_eof = 1'b0;
    rst_n = 1'b1;

    send_pkt(8'd17, 5, 0, 0, 30);   // header-only datagram, correct sum
    send_pkt(8'd17, 5, 0, 2, 0);    // header-only, corrupted
    send_pkt(8'd17, 5, 1, 0, 0);    // R8 odd single byte, garbage after
    send_pkt(8'd17, 5, 3, 2, 20);   // R8 odd length, corrupted
    send_pkt(8'd17, 5, 12, 1, 0);   // R6 zero checksum
    send_pkt(8'd6, 5, 16, 2, 0);    // R4 non-UDP, wrong field ignored
    send_pkt(8'd16, 5, 4, 0, 40);   // R2 neighbour protocol value
    send_pkt(8'd17, 6, 9, 0, 50);   // options move the UDP header, R5 bubbles
    send_pkt(8'd17, 7, 10, 2, 0);
    for (int r = 0; r < 80; r++) begin
      send_pkt(($urandom_range(0, 3) != 0) ? 8'd17 : 8'($urandom_range(0, 255)),
               $urandom_range(5, 8), $urandom_range(0, 100), $urandom_range(0, 2),
               $urandom_range(0, 40));
    end
    step(32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule